// File: doc/BRIEF.md
# Register Bank Slave with Acknowledged Writes

This block is a small bank of software-visible data registers that sits on a memory-mapped command port. Every command is presented in one cycle. For a write, that cycle carries the address, the data and the per-byte enables. Reads are split-phase. The bank takes a read command in one cycle and hands the data back a fixed number of cycles later on a separate return channel. Several reads can therefore be in flight at once.

Writes are non-posted. Each accepted write is later acknowledged with a 2-bit status code on its own return channel. The slave cannot tell whether the master cares about that acknowledgement, so it always produces one. The number of writes that are accepted but not yet acknowledged is capped by `PENDING_WRITES`. When the cap is reached, the slave holds off further writes with its wait signal.

Status codes are 00 for success and 11 for an address that decodes to no register. The codes 01 and 10 are reserved for other conditions. A read and a write requested in the same cycle are refused together.

Top module: `mmrsp_slave`

## Requirements
- R1: A write accepted to an address below `NUM_REGS` updates only the bytes whose enable bit is set; enable bit b covers data bits 8b+7 down to 8b. A read accepted in any later cycle returns the updated value.
- R2: A read accepted in cycle c is answered in cycle c+`RD_LATENCY` with `rd_valid` high for exactly one cycle. The answer carries the register value as it stood when the read was accepted and code 00 on `rd_resp`. Back-to-back reads are answered one per cycle, in command order.
- R3: Each accepted write produces exactly one cycle of `wr_resp_valid`, in cycle c+`WR_LATENCY` for a write accepted in cycle c. Acknowledgements come in acceptance order, and a write to a present register is acknowledged with code 00.
- R4: The count of accepted but unacknowledged writes never exceeds `PENDING_WRITES`. While that count equals the cap, a presented write sees `cmd_wait` high and is not taken. It becomes acceptable in the cycle after the acknowledgement that frees a slot has been presented.
- R5: An address at or above `NUM_REGS` is a decode miss. A write to it changes no register and is acknowledged with code 11. A read from it is answered with code 11 and all-zero data.
- R6: When `cmd_read` and `cmd_write` are high together, `cmd_wait` is high and neither command is taken. No acknowledgement and no read answer follow, and no register changes.
- R7: A read presented without a write is never held off: `cmd_wait` stays low.
- R8: A synchronous active-low reset clears every register to zero and discards every answer and acknowledgement still in flight. After reset, none of them is ever presented.
- R9: The bank never presents code 01 or code 10 on either return channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_byteen | input | DATA_W/8 | Byte enables for a write |
| cmd_wdata | input | DATA_W | Write data, presented with the write command |
| cmd_write | input | 1 | Write request |
| cmd_read | input | 1 | Read request |
| cmd_wait | output | 1 | High when the presented command is not taken this cycle |
| rd_valid | output | 1 | Read answer strobe |
| rd_data | output | DATA_W | Read answer data |
| rd_resp | output | 2 | Read status code |
| wr_resp_valid | output | 1 | Write acknowledgement strobe |
| wr_resp | output | 2 | Write status code |

## Verification
A stimulus table exercises the bank with several patterns: full-word writes, sparse byte-enable patterns, reads straight after writes to the same register, back-to-back reads of different registers, and addresses just past the bank and far past it. Each pattern separates a different fault: byte-lane masking, read-after-write ordering, return ordering, and decode of the upper address boundary. Further directed tests cover the rest. A burst of writes is sent until the acknowledgement cap is hit, and the exact length of the stall is measured. Read and write are requested together, with a check that nothing is taken and that storage is untouched. Reset is asserted while acknowledgements are still in flight, to show that they are discarded and that storage is cleared.

// File: rtl/mmrsp_pkg.sv
// Shared definitions for the register bank slave.
// Assumes: the 2-bit status code is shared by read answers and write
// acknowledgements.
package mmrsp_pkg;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_RSVD   = 2'b01,
        RESP_SLVERR = 2'b10,
        RESP_DECERR = 2'b11
    } resp_e;

endpackage

// File: rtl/mmrsp_cmd_gate.sv
// Command gate: decides which command, if any, is taken in the current cycle.
// Assumes: at most one command per cycle; the full flag comes from a registered
// counter, so this gate is purely combinational.
module mmrsp_cmd_gate (
    input  logic rd_req,
    input  logic wr_req,
    input  logic wr_full,
    output logic acc_rd,
    output logic acc_wr,
    output logic stall
);

    logic conflict;

    // Classify the request and produce the accept strobes and the stall.
    always_comb begin
        conflict = rd_req & wr_req;
        acc_rd   = rd_req & ~wr_req;
        acc_wr   = wr_req & ~rd_req & ~wr_full;
        stall    = conflict | (wr_req & wr_full);
    end

endmodule

// File: rtl/mmrsp_regbank.sv
// Register storage with byte-lane writes and a combinational read mux.
// Assumes: NUM_REGS is below 2**ADDR_W; addresses at or above NUM_REGS
// decode to nothing and read as zero.
module mmrsp_regbank #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_W/8-1:0]   be,
    output logic [DATA_W-1:0]     rdata,
    output logic                  hit
);

    localparam int              BE_W  = DATA_W / 8;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_REGS);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    // Address decode: inside the bank or not.
    always_comb begin
        hit = ({1'b0, addr} < LIMIT);
    end

    // Storage update, byte lane by byte lane, for the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (wr_en && hit) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (addr == ADDR_W'(r)) begin
                    for (int b = 0; b < BE_W; b++) begin
                        if (be[b]) begin
                            regs[r][8*b +: 8] <= wdata[8*b +: 8];
                        end
                    end
                end
            end
        end
    end

    // Read selection; a miss leaves the result at zero.
    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (addr == ADDR_W'(r)) begin
                rdata = regs[r];
            end
        end
    end

endmodule

// File: rtl/mmrsp_return_pipe.sv
// Fixed-latency return path: a strobe plus payload shifted through STAGES
// registers.
// Assumes: STAGES >= 1; the payload is zeroed in stages that carry no strobe,
// so the output payload reads zero when the strobe is low.
module mmrsp_return_pipe #(
    parameter int STAGES = 4,
    parameter int PAY_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PAY_W-1:0] in_pay,
    output logic             out_valid,
    output logic [PAY_W-1:0] out_pay
);

    logic [STAGES-1:0]            vld;
    logic [STAGES-1:0][PAY_W-1:0] pay;

    // Shift the strobe and the payload one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            pay <= '0;
        end else begin
            vld[0] <= in_valid;
            pay[0] <= in_valid ? in_pay : '0;
            for (int s = 1; s < STAGES; s++) begin
                vld[s] <= vld[s-1];
                pay[s] <= pay[s-1];
            end
        end
    end

    // Present the last stage.
    always_comb begin
        out_valid = vld[STAGES-1];
        out_pay   = pay[STAGES-1];
    end

endmodule

// File: rtl/mmrsp_wr_credit.sv
// Counter of accepted but unacknowledged writes, with a full flag.
// Assumes: take is never asserted while full, and give only while the count
// is non-zero.
module mmrsp_wr_credit #(
    parameter int PENDING_WRITES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic full
);

    localparam int CNT_W = $clog2(PENDING_WRITES + 1);

    logic [CNT_W-1:0] cnt;

    // Track the outstanding count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case ({take, give})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // Flag the cap.
    always_comb begin
        full = (cnt == CNT_W'(PENDING_WRITES));
    end

endmodule

// File: rtl/mmrsp_slave.sv
// Register bank slave with split-phase reads and acknowledged writes.
// Assumes: one command per cycle; the read and write return paths have fixed
// latencies, so answers stay in command order without tags; the write
// acknowledgement count is capped at PENDING_WRITES.
module mmrsp_slave
    import mmrsp_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 32,
    parameter int NUM_REGS       = 8,
    parameter int PENDING_WRITES = 2,
    parameter int WR_LATENCY     = 4,
    parameter int RD_LATENCY     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [DATA_W/8-1:0]   cmd_byteen,
    input  logic [DATA_W-1:0]     cmd_wdata,
    input  logic                  cmd_write,
    input  logic                  cmd_read,
    output logic                  cmd_wait,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    output logic [1:0]            rd_resp,
    output logic                  wr_resp_valid,
    output logic [1:0]            wr_resp
);

    localparam int RD_PAY_W = DATA_W + 2;

    logic                acc_rd;
    logic                acc_wr;
    logic                wr_full;
    logic                hit;
    logic [DATA_W-1:0]   bank_rdata;
    logic [1:0]          cmd_code;
    logic [RD_PAY_W-1:0] rd_pay;

    mmrsp_cmd_gate u_gate (
        .rd_req  (cmd_read),
        .wr_req  (cmd_write),
        .wr_full (wr_full),
        .acc_rd  (acc_rd),
        .acc_wr  (acc_wr),
        .stall   (cmd_wait)
    );

    mmrsp_regbank #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (acc_wr),
        .addr  (cmd_addr),
        .wdata (cmd_wdata),
        .be    (cmd_byteen),
        .rdata (bank_rdata),
        .hit   (hit)
    );

    // Status code for the command being taken.
    always_comb begin
        cmd_code = hit ? RESP_OKAY : RESP_DECERR;
    end

    mmrsp_wr_credit #(
        .PENDING_WRITES (PENDING_WRITES)
    ) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (acc_wr),
        .give  (wr_resp_valid),
        .full  (wr_full)
    );

    mmrsp_return_pipe #(
        .STAGES (WR_LATENCY),
        .PAY_W  (2)
    ) u_wr_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (acc_wr),
        .in_pay    (cmd_code),
        .out_valid (wr_resp_valid),
        .out_pay   (wr_resp)
    );

    mmrsp_return_pipe #(
        .STAGES (RD_LATENCY),
        .PAY_W  (RD_PAY_W)
    ) u_rd_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (acc_rd),
        .in_pay    ({cmd_code, bank_rdata}),
        .out_valid (rd_valid),
        .out_pay   (rd_pay)
    );

    // Split the read return payload onto the output ports.
    always_comb begin
        rd_resp = rd_pay[RD_PAY_W-1 -: 2];
        rd_data = rd_pay[DATA_W-1:0];
    end

endmodule

// File: rtl/mmrsp_slave_chk.sv
// Protocol checker for mmrsp_slave, attached by bind below.
// Assumes: the same latency and cap parameters as the bound instance; it
// keeps its own acceptance history from the port signals.
module mmrsp_slave_chk #(
    parameter int PENDING_WRITES = 2,
    parameter int WR_LATENCY     = 4,
    parameter int RD_LATENCY     = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_write,
    input logic       cmd_read,
    input logic       cmd_wait,
    input logic       rd_valid,
    input logic [1:0] rd_resp,
    input logic       wr_resp_valid,
    input logic [1:0] wr_resp
);

    logic                  ck_acc_wr;
    logic                  ck_acc_rd;
    logic [WR_LATENCY-1:0] wr_hist;
    logic [RD_LATENCY-1:0] rd_hist;
    logic [31:0]           ck_open;

    // Acceptance as seen at the ports.
    always_comb begin
        ck_acc_wr = cmd_write & ~cmd_read & ~cmd_wait;
        ck_acc_rd = cmd_read & ~cmd_write & ~cmd_wait;
    end

    // Acceptance histories, one bit per cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_hist <= '0;
            rd_hist <= '0;
        end else begin
            wr_hist[0] <= ck_acc_wr;
            rd_hist[0] <= ck_acc_rd;
            for (int i = 1; i < WR_LATENCY; i++) wr_hist[i] <= wr_hist[i-1];
            for (int i = 1; i < RD_LATENCY; i++) rd_hist[i] <= rd_hist[i-1];
        end
    end

    // Count of writes taken but not yet acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_open <= '0;
        end else begin
            ck_open <= ck_open + {31'd0, ck_acc_wr} - {31'd0, wr_resp_valid};
        end
    end

    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == rd_hist[RD_LATENCY-1]);

    p_write_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_resp_valid == wr_hist[WR_LATENCY-1]);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ck_open <= 32'(PENDING_WRITES));

    p_full_holds_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_write && ck_open == 32'(PENDING_WRITES)) |-> cmd_wait);

    p_conflict_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && cmd_write) |-> cmd_wait);

    p_read_never_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && !cmd_write) |-> !cmd_wait);

    p_wr_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_resp_valid |-> (wr_resp == 2'b00 || wr_resp == 2'b11));

    p_rd_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_resp == 2'b00 || rd_resp == 2'b11));

endmodule

bind mmrsp_slave mmrsp_slave_chk #(
    .PENDING_WRITES (PENDING_WRITES),
    .WR_LATENCY     (WR_LATENCY),
    .RD_LATENCY     (RD_LATENCY)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_write     (cmd_write),
    .cmd_read      (cmd_read),
    .cmd_wait      (cmd_wait),
    .rd_valid      (rd_valid),
    .rd_resp       (rd_resp),
    .wr_resp_valid (wr_resp_valid),
    .wr_resp       (wr_resp)
);

// File: tb/tb_mmrsp_slave.sv
// Self-checking bench for mmrsp_slave: a table of commands, then directed
// tests for reset, conflicts, the acknowledgement cap and reset in flight.
module tb_mmrsp_slave;

    localparam int CLK_PERIOD     = 10;
    localparam int NUM_REGS       = 8;
    localparam int PENDING_WRITES = 2;
    localparam int WR_LATENCY     = 4;
    localparam int RD_LATENCY     = 2;
    localparam int IDX_W          = $clog2(NUM_REGS);
    localparam int N_VEC          = 14;

    // Vector: {op(1=write,2=read), expected code, addr, byte enables, data}
    localparam logic [47:0] VECS [N_VEC] = '{
        {2'd1, 2'b00, 8'h00, 4'hF, 32'h11223344},
        {2'd1, 2'b00, 8'h01, 4'hF, 32'hA5A5A5A5},
        {2'd2, 2'b00, 8'h00, 4'h0, 32'h00000000},
        {2'd2, 2'b00, 8'h01, 4'h0, 32'h00000000},
        {2'd1, 2'b00, 8'h00, 4'h5, 32'hFFFFFFFF},
        {2'd2, 2'b00, 8'h00, 4'h0, 32'h00000000},
        {2'd1, 2'b00, 8'h07, 4'hF, 32'hDEADBEEF},
        {2'd1, 2'b11, 8'h08, 4'hF, 32'h12345678},
        {2'd2, 2'b11, 8'h08, 4'h0, 32'h00000000},
        {2'd2, 2'b00, 8'h07, 4'h0, 32'h00000000},
        {2'd1, 2'b11, 8'h40, 4'hF, 32'h55555555},
        {2'd2, 2'b00, 8'h00, 4'h0, 32'h00000000},
        {2'd1, 2'b00, 8'h03, 4'h8, 32'hCAFEF00D},
        {2'd2, 2'b00, 8'h03, 4'h0, 32'h00000000}
    };

    logic        clk;
    logic        rst_n;
    logic [7:0]  cmd_addr;
    logic [3:0]  cmd_byteen;
    logic [31:0] cmd_wdata;
    logic        cmd_write;
    logic        cmd_read;
    logic        cmd_wait;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [1:0]  rd_resp;
    logic        wr_resp_valid;
    logic [1:0]  wr_resp;

    mmrsp_slave #(
        .ADDR_W (8), .DATA_W (32), .NUM_REGS (NUM_REGS),
        .PENDING_WRITES (PENDING_WRITES),
        .WR_LATENCY (WR_LATENCY), .RD_LATENCY (RD_LATENCY)
    ) dut (
        .clk (clk), .rst_n (rst_n), .cmd_addr (cmd_addr),
        .cmd_byteen (cmd_byteen), .cmd_wdata (cmd_wdata),
        .cmd_write (cmd_write), .cmd_read (cmd_read), .cmd_wait (cmd_wait),
        .rd_valid (rd_valid), .rd_data (rd_data), .rd_resp (rd_resp),
        .wr_resp_valid (wr_resp_valid), .wr_resp (wr_resp)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    int last_stalls = 0;
    string tag = "R8";

    logic [31:0] shadow [NUM_REGS];

    int          wq_cyc  [256];
    logic [1:0]  wq_code [256];
    string       wq_tag  [256];
    logic [7:0]  wh = 8'd0;
    logic [7:0]  wt = 8'd0;
    int          rq_cyc  [256];
    logic [1:0]  rq_code [256];
    logic [31:0] rq_data [256];
    string       rq_tag  [256];
    logic [7:0]  rh = 8'd0;
    logic [7:0]  rt = 8'd0;

    task automatic chk(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Present one command, wait until it is taken, then record its answer.
    task automatic do_cmd(input int op, input logic [7:0] a, input logic [3:0] be,
                          input logic [31:0] d, input logic [1:0] code);
        cmd_addr   = a;
        cmd_byteen = be;
        cmd_wdata  = d;
        cmd_write  = (op == 1);
        cmd_read   = (op == 2);
        last_stalls = 0;
        #1;
        while (cmd_wait) begin
            last_stalls++;
            if (op == 2) chk(1'b0, "R7 read held off", 64'(cmd_wait), 64'd0);
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        if (op == 1) begin
            wq_cyc[wt] = cyc + WR_LATENCY - 1;
            wq_code[wt] = code;
            wq_tag[wt] = tag;
            wt = wt + 8'd1;
            if (int'(a) < NUM_REGS) begin
                for (int b = 0; b < 4; b++) begin
                    if (be[b]) shadow[a[IDX_W-1:0]][8*b +: 8] = d[8*b +: 8];
                end
            end
        end else begin
            rq_cyc[rt] = cyc + RD_LATENCY - 1;
            rq_code[rt] = code;
            rq_data[rt] = (int'(a) < NUM_REGS) ? shadow[a[IDX_W-1:0]] : 32'd0;
            rq_tag[rt] = tag;
            rt = rt + 8'd1;
        end
        cmd_write = 1'b0;
        cmd_read  = 1'b0;
    endtask

    // Match every answer against the expected queue and its cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_resp_valid) begin
                if (wh == wt) begin
                    chk(1'b0, "R3 R6 unexpected write acknowledgement", 64'(wr_resp), 64'd0);
                end else begin
                    chk(cyc == wq_cyc[wh], {wq_tag[wh], " acknowledgement cycle"},
                        64'(cyc), 64'(wq_cyc[wh]));
                    chk(wr_resp == wq_code[wh], {wq_tag[wh], " acknowledgement code"},
                        64'(wr_resp), 64'(wq_code[wh]));
                    wh = wh + 8'd1;
                end
            end else if (wh != wt && cyc >= wq_cyc[wh]) begin
                chk(1'b0, {wq_tag[wh], " missing acknowledgement"}, 64'(cyc), 64'(wq_cyc[wh]));
                wh = wh + 8'd1;
            end
            if (rd_valid) begin
                if (rh == rt) begin
                    chk(1'b0, "R2 R6 unexpected read answer", 64'(rd_data), 64'd0);
                end else begin
                    chk(cyc == rq_cyc[rh], {rq_tag[rh], " read answer cycle"},
                        64'(cyc), 64'(rq_cyc[rh]));
                    chk(rd_resp == rq_code[rh], {rq_tag[rh], " read answer code"},
                        64'(rd_resp), 64'(rq_code[rh]));
                    chk(rd_data == rq_data[rh], {rq_tag[rh], " read answer data"},
                        64'(rd_data), 64'(rq_data[rh]));
                    rh = rh + 8'd1;
                end
            end else if (rh != rt && cyc >= rq_cyc[rh]) begin
                chk(1'b0, {rq_tag[rh], " missing read answer"}, 64'(cyc), 64'(rq_cyc[rh]));
                rh = rh + 8'd1;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R2 R3 watchdog expired", 64'(cyc), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        cmd_addr   = '0;
        cmd_byteen = '0;
        cmd_wdata  = '0;
        cmd_write  = 1'b0;
        cmd_read   = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: outputs idle after reset and every register reads zero.
        chk(!rd_valid && !wr_resp_valid, "R8 return strobes idle after reset",
            64'({rd_valid, wr_resp_valid}), 64'd0);
        chk(cmd_wait == 1'b0, "R8 no wait when idle", 64'(cmd_wait), 64'd0);
        tag = "R8 reset value";
        for (int i = 0; i < NUM_REGS; i++) do_cmd(2, 8'(i), 4'h0, 32'd0, 2'b00);

        // Table walk: R1, R2, R3, R5, R9 under several patterns.
        for (int v = 0; v < N_VEC; v++) begin
            if (VECS[v][47:46] == 2'd1)
                tag = (VECS[v][45:44] == 2'b11) ? "R5 R3 R9 miss write" : "R1 R3 R9 write";
            else
                tag = (VECS[v][45:44] == 2'b11) ? "R5 R9 miss read" : "R1 R2 R9 read";
            do_cmd(int'(VECS[v][47:46]), VECS[v][43:36], VECS[v][35:32],
                   VECS[v][31:0], VECS[v][45:44]);
        end
        repeat (WR_LATENCY + 2) @(negedge clk);

        // R6: read and write together are both refused.
        cmd_addr   = 8'h01;
        cmd_byteen = 4'hF;
        cmd_wdata  = 32'h0BADF00D;
        cmd_read   = 1'b1;
        cmd_write  = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(cmd_wait == 1'b1, "R6 conflict raises wait", 64'(cmd_wait), 64'd1);
            @(negedge clk);
        end
        cmd_read  = 1'b0;
        cmd_write = 1'b0;
        repeat (WR_LATENCY + 2) @(negedge clk);
        tag = "R6 storage untouched";
        do_cmd(2, 8'h01, 4'h0, 32'd0, 2'b00);
        repeat (RD_LATENCY + 2) @(negedge clk);

        // R4: fill the acknowledgement cap, then measure the stall.
        tag = "R4 R3 capped write";
        for (int k = 0; k < PENDING_WRITES; k++)
            do_cmd(1, 8'(2 + k), 4'hF, 32'h01010101 * 32'(k + 1), 2'b00);
        cmd_addr  = 8'h05;
        cmd_write = 1'b1;
        #1;
        chk(cmd_wait == 1'b1, "R4 write held at cap", 64'(cmd_wait), 64'd1);
        do_cmd(1, 8'h05, 4'hF, 32'h77777777, 2'b00);
        chk(last_stalls == WR_LATENCY - PENDING_WRITES + 1, "R4 stall length at cap",
            64'(last_stalls), 64'(WR_LATENCY - PENDING_WRITES + 1));
        tag = "R4 R1 read after capped writes";
        do_cmd(2, 8'h05, 4'h0, 32'd0, 2'b00);
        repeat (WR_LATENCY + 2) @(negedge clk);

        // R8: reset with acknowledgements in flight discards them.
        tag = "R8 in flight";
        do_cmd(1, 8'h06, 4'hF, 32'h66666666, 2'b00);
        do_cmd(1, 8'h06, 4'h3, 32'h12341234, 2'b00);
        rst_n = 1'b0;
        wh = wt;
        rh = rt;
        for (int i = 0; i < NUM_REGS; i++) shadow[i] = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < WR_LATENCY + 2; k++) begin
            @(negedge clk);
            chk(!wr_resp_valid && !rd_valid, "R8 nothing presented after reset",
                64'({wr_resp_valid, rd_valid}), 64'd0);
        end
        tag = "R8 cleared register";
        do_cmd(2, 8'h06, 4'h0, 32'd0, 2'b00);
        do_cmd(2, 8'h05, 4'h0, 32'd0, 2'b00);

        repeat (WR_LATENCY + RD_LATENCY + 4) @(negedge clk);
        chk(wh == wt && rh == rt, "R2 R3 every answer delivered",
            64'({wt - wh, rt - rh}), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule